// File: doc/BRIEF.md
# PS/2 Host-to-Device Command Transmitter

This block sends one command byte from the host side of a PS/2 link to an attached keyboard, for instance a request for the keyboard to repeat its last code. Both link wires are open-drain: the block only ever pulls a wire low or lets it float, and reads the wire levels back through synchronisers. To claim the link it holds the clock wire low for a fixed interval, then pulls the data wire low as a start bit and lets the clock go. The keyboard then generates the clock. The block places a new bit on the data wire after each falling clock edge, so the bit is stable when the keyboard samples it on the rising edge.

The frame carries eight data bits, least significant first, then an odd-parity bit, then a released (high) stop bit. The block then waits for the keyboard to acknowledge by pulling data low, and waits for the clock to go low before it finishes. For the whole transfer the block asks the local frame receiver to stay disabled. At the end it pulses a request to restart the receiver's inter-bit timeout. A watchdog ends the transfer and frees both wires if the keyboard stops producing clock edges.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, neither wire is pulled low, and `busy_o`, `done_o` and `abort_o` are low.
- R2: A `start_i` pulse while idle sets `busy_o` on the next cycle. The clock wire alone is then pulled low for exactly `RTS_CYCLES` cycles.
- R3: At the end of the hold, the data wire is pulled low while the clock wire stays low for one more cycle. After that the clock wire is released and the data wire stays low.
- R4: Falling clock edges 1 to 8 each present the next data bit, least significant bit first. A bit value of 0 pulls the wire low and a value of 1 releases it.
- R5: Falling clock edge 9 presents the parity bit, which is 1 when the byte holds an even number of ones.
- R6: While transmitting with the clock released by the host, the data drive changes only while the synchronised clock line is low.
- R7: Falling clock edge 10 releases the data wire as the stop bit. After the following rising edge, the block waits for data low (acknowledge) and then clock low. It then raises `done_o` for one cycle, in which `busy_o` is already low.
- R8: `start_i` is ignored while `busy_o` is high. The byte sent and the hold timing are those of the first request.
- R9: `rx_inhibit_o` equals `busy_o`. `rx_rearm_o` pulses in the cycle where `busy_o` falls, whether the transfer completed or was aborted.
- R10: Once the clock has been released, if `WDOG_CYCLES` cycles pass with no edge on the synchronised clock line, the block aborts. It releases both wires, pulses `abort_o` (not `done_o`) and returns idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send `cmd_i` (one-cycle pulse) |
| cmd_i | input | DATA_W | Command byte, sampled with `start_i` |
| ps2_clk_i | input | 1 | Level read back from the clock wire (asynchronous) |
| ps2_dat_i | input | 1 | Level read back from the data wire (asynchronous) |
| ps2_clk_low_o | output | 1 | Pull the clock wire low when high |
| ps2_dat_low_o | output | 1 | Pull the data wire low when high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on acknowledged completion |
| abort_o | output | 1 | One-cycle pulse on watchdog abort |
| rx_inhibit_o | output | 1 | Keep the frame receiver disabled |
| rx_rearm_o | output | 1 | One-cycle pulse to restart the receiver timeout |

## Verification
The assertions assume that the keyboard holds each clock phase for several cycles longer than the synchroniser latency. They also assume it starts clocking only after the host has released the clock, and acknowledges only after sampling the stop bit. The bench keyboard model keeps every clock phase at 20 cycles and waits 10 cycles before its first pulse. It pulls data low a few cycles before pulling clock low for the acknowledge. Random bytes, directed all-zero, all-one and resend-style bytes, a start request during the hold, and two stalled keyboards exercise the paths within these limits.

// File: rtl/ps2_cmd_pkg.sv
// Shared types for the PS/2 host command transmitter.
// Assumes: nothing beyond the enum encoding being private to this block.
package ps2_cmd_pkg;

    // Transfer phases of the transmitter controller.
    typedef enum logic [2:0] {
        ST_IDLE,      // wires released, waiting for a request
        ST_RTS,       // clock wire held low for the claim interval
        ST_START,     // data pulled low, clock still low for one cycle
        ST_FRAME,     // presenting data, parity and stop on falling edges
        ST_STOP,      // waiting for the rising edge that samples the stop bit
        ST_WAIT_ACK,  // waiting for the device to pull data low
        ST_WAIT_CLK   // waiting for the device to pull clock low
    } tx_state_e;

endpackage

// File: rtl/ps2_line_sync.sv
// Multi-stage synchroniser for the open-drain wire read-backs.
// Assumes: inputs are asynchronous; idle wires float high, so stages reset to 1.
module ps2_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] level_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] pipe_q;

            // Shift the wire level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '1;
                end else begin
                    pipe_q <= {pipe_q[STAGES-2:0], line_i[g]};
                end
            end

            assign level_o[g] = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ps2_cmd_timer.sv
// Claim-interval counter and inactivity watchdog for the transmitter.
// Assumes: run inputs come from the controller state; kick marks a clock edge.
module ps2_cmd_timer #(
    parameter int RTS_CYCLES  = 12500,
    parameter int WDOG_CYCLES = 375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_run_i,
    input  logic wdog_run_i,
    input  logic wdog_kick_i,
    output logic rts_elapsed_o,
    output logic wdog_expired_o
);

    localparam int RTS_W  = $clog2(RTS_CYCLES + 1);
    localparam int WDOG_W = $clog2(WDOG_CYCLES + 1);
    localparam logic [RTS_W-1:0]  RTS_LAST  = RTS_W'(RTS_CYCLES - 1);
    localparam logic [WDOG_W-1:0] WDOG_LAST = WDOG_W'(WDOG_CYCLES - 1);

    logic [RTS_W-1:0]  rts_cnt_q;
    logic [WDOG_W-1:0] wd_cnt_q;

    // Count cycles spent holding the clock wire low.
    always_ff @(posedge clk) begin
        if (!rst_n || !rts_run_i) begin
            rts_cnt_q <= '0;
        end else if (rts_cnt_q != RTS_LAST) begin
            rts_cnt_q <= rts_cnt_q + 1'b1;
        end
    end

    // Count cycles since the last clock edge while the device owns the clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !wdog_run_i || wdog_kick_i) begin
            wd_cnt_q <= '0;
        end else if (wd_cnt_q != WDOG_LAST) begin
            wd_cnt_q <= wd_cnt_q + 1'b1;
        end
    end

    assign rts_elapsed_o  = rts_run_i && (rts_cnt_q == RTS_LAST);
    assign wdog_expired_o = wdog_run_i && !wdog_kick_i && (wd_cnt_q == WDOG_LAST);

    // R2: the hold counter never passes its final value.
    assert_rts_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rts_cnt_q <= RTS_LAST);

    // R10: the watchdog count stays within its window.
    assert_wdog_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cnt_q <= WDOG_LAST);

    // R10: a run that ends on expiry restarts from zero.
    assert_wdog_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wdog_run_i |=> wd_cnt_q == '0);

endmodule

// File: rtl/ps2_cmd_shifter.sv
// Frame shift register: data bits LSB first, odd parity, released stop bit.
// Assumes: load only while idle; one shift per falling clock edge of the frame.
module ps2_cmd_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;

    // Load a fresh frame or move to the next bit on each presented edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else if (load_i) begin
            sh_q  <= {1'b1, ~(^byte_i), byte_i};
            cnt_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (cnt_q == CNT_LAST);

    // R4: no more shifts than the frame has bits.
    assert_shift_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> cnt_q < CNT_W'(FRAME_W));

    // R8: a new frame never loads while a shift is requested.
    assert_no_load_mid_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/ps2_cmd_tx.sv
// PS/2 host-to-device command transmitter top: claims the link, sends one
// byte on device-generated clocks, waits for the acknowledge.
// Assumes: wires are open-drain with pull-ups; this block only pulls low.
module ps2_cmd_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RTS_CYCLES  = 12500,
    parameter int WDOG_CYCLES = 375000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic              ps2_clk_low_o,
    output logic              ps2_dat_low_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              abort_o,
    output logic              rx_inhibit_o,
    output logic              rx_rearm_o
);

    import ps2_cmd_pkg::*;

    localparam int LINE_CLK = 0;
    localparam int LINE_DAT = 1;

    tx_state_e  state_q;
    logic       clk_low_q, dat_low_q, done_q, abort_q;
    logic [1:0] line_lvl;
    logic       clk_lvl, dat_lvl, clk_prev_q, clk_fall, clk_rise;
    logic       rts_elapsed, wdog_expired, wdog_run;
    logic       sh_load, sh_shift, sh_bit, sh_last;

    ps2_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  ({ps2_dat_i, ps2_clk_i}),
        .level_o (line_lvl)
    );

    assign clk_lvl = line_lvl[LINE_CLK];
    assign dat_lvl = line_lvl[LINE_DAT];

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b1;
        else        clk_prev_q <= clk_lvl;
    end

    assign clk_fall = clk_prev_q && !clk_lvl;
    assign clk_rise = !clk_prev_q && clk_lvl;

    assign wdog_run = (state_q == ST_FRAME) || (state_q == ST_STOP) ||
                      (state_q == ST_WAIT_ACK) || (state_q == ST_WAIT_CLK);

    ps2_cmd_timer #(.RTS_CYCLES(RTS_CYCLES), .WDOG_CYCLES(WDOG_CYCLES)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .rts_run_i      (state_q == ST_RTS),
        .wdog_run_i     (wdog_run),
        .wdog_kick_i    (clk_fall || clk_rise),
        .rts_elapsed_o  (rts_elapsed),
        .wdog_expired_o (wdog_expired)
    );

    assign sh_load  = (state_q == ST_IDLE) && start_i;
    assign sh_shift = (state_q == ST_FRAME) && clk_fall && !wdog_expired;

    ps2_cmd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .byte_i  (cmd_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    // Sequence the claim, frame, acknowledge and watchdog abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            clk_low_q <= 1'b0;
            dat_low_q <= 1'b0;
            done_q    <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        clk_low_q <= 1'b1;
                        state_q   <= ST_RTS;
                    end
                end
                ST_RTS: begin
                    if (rts_elapsed) begin
                        dat_low_q <= 1'b1;
                        state_q   <= ST_START;
                    end
                end
                ST_START: begin
                    clk_low_q <= 1'b0;
                    state_q   <= ST_FRAME;
                end
                ST_FRAME: begin
                    if (clk_fall) begin
                        dat_low_q <= ~sh_bit;
                        if (sh_last) state_q <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (clk_rise) state_q <= ST_WAIT_ACK;
                end
                ST_WAIT_ACK: begin
                    if (!dat_lvl) state_q <= ST_WAIT_CLK;
                end
                ST_WAIT_CLK: begin
                    if (!clk_lvl) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (wdog_expired) begin
                clk_low_q <= 1'b0;
                dat_low_q <= 1'b0;
                done_q    <= 1'b0;
                abort_q   <= 1'b1;
                state_q   <= ST_IDLE;
            end
        end
    end

    assign ps2_clk_low_o = clk_low_q;
    assign ps2_dat_low_o = dat_low_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign done_o        = done_q;
    assign abort_o       = abort_q;
    assign rx_inhibit_o  = busy_o;
    assign rx_rearm_o    = done_q || abort_q;

    // R1: an idle block leaves both wires floating.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ps2_clk_low_o && !ps2_dat_low_o);

    // R2: an accepted request starts the clock-only hold.
    assert_claim_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && ps2_clk_low_o && !ps2_dat_low_o);

    // R3: the host lets go of the clock only with data already pulled low.
    assert_clk_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_low_o) && busy_o |-> ps2_dat_low_o);

    // R6: data drive moves only while the device holds the clock low.
    assert_data_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && !ps2_clk_low_o && !$stable(ps2_dat_low_o) |-> !clk_lvl);

    // R7: completion is reported once the block is already idle.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !abort_o);

    // R9: every end of a transfer asks the receiver to restart its timeout.
    assert_rearm_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> rx_rearm_o);

endmodule

// File: tb/ps2_cmd_tx_tb.sv
module ps2_cmd_tx_tb;

    localparam int RTS  = 100;
    localparam int WDOG = 600;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic kbd_clk_low = 1'b0;
    logic kbd_dat_low = 1'b0;
    logic clk_line, dat_line;
    logic clk_dr, dat_dr, busy, done, abort_p, inhibit, rearm;

    int checks = 0;
    int errors = 0;
    int stab_viol = 0;
    int inh_viol = 0;

    always #4 clk = ~clk;

    assign clk_line = ~(clk_dr | kbd_clk_low);
    assign dat_line = ~(dat_dr | kbd_dat_low);

    ps2_cmd_tx #(.DATA_W(8), .SYNC_STAGES(2), .RTS_CYCLES(RTS), .WDOG_CYCLES(WDOG)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .cmd_i         (cmd),
        .ps2_clk_i     (clk_line),
        .ps2_dat_i     (dat_line),
        .ps2_clk_low_o (clk_dr),
        .ps2_dat_low_o (dat_dr),
        .busy_o        (busy),
        .done_o        (done),
        .abort_o       (abort_p),
        .rx_inhibit_o  (inhibit),
        .rx_rearm_o    (rearm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_parity(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += b[i];
        return (ones % 2 == 0);
    endfunction

    // R9 monitor: receiver inhibit must follow busy.
    always @(negedge clk) if (rst_n && (inhibit !== busy)) inh_viol++;

    // One transfer with a keyboard model giving `pulses` clock pulses.
    task automatic run_tx(input logic [7:0] b, input int pulses, input bit ack, input bit poke);
        int cnt;
        int total;
        logic [7:0] got;
        logic par, stp, held, seen_done;
        got = 8'h00; par = 1'b0; stp = 1'b0; seen_done = 1'b0;
        @(negedge clk); start = 1'b1; cmd = b;
        @(negedge clk); start = 1'b0; cmd = 8'h00;
        check(busy === 1'b1 && clk_dr === 1'b1, "R2 busy and clock pulled", busy, 1);
        cnt = 0;
        while (clk_dr && !dat_dr && cnt < RTS + 50) begin
            cnt++;
            if (poke && cnt == 5) begin start = 1'b1; cmd = ~b; end
            else begin start = 1'b0; cmd = 8'h00; end
            @(negedge clk);
        end
        start = 1'b0;
        check(cnt == RTS, "R2 clock-only hold length", cnt, RTS);
        check(clk_dr && dat_dr, "R3 data low with clock low", {clk_dr, dat_dr}, 3);
        @(negedge clk);
        check(!clk_dr && dat_dr, "R3 clock released data held", {clk_dr, dat_dr}, 1);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (i >= pulses) break;
            kbd_clk_low = 1'b1;
            repeat (HALF) @(negedge clk);
            held = dat_line;
            if (i < 8) got[i] = held;
            else if (i == 8) par = held;
            else stp = held;
            kbd_clk_low = 1'b0;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk);
                if (dat_line !== held) stab_viol++;
            end
        end
        if (pulses >= 10) begin
            check(got == b, "R4 byte LSB first", got, b);
            check(par == exp_parity(b), "R5 odd parity", par, exp_parity(b));
            check(stp == 1'b1, "R7 stop released", stp, 1);
        end
        if (pulses >= 10 && ack) begin
            kbd_dat_low = 1'b1;
            repeat (4) @(negedge clk);
            check(busy && !done, "R7 no finish before clock low", {busy, done}, 2);
            kbd_clk_low = 1'b1;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk);
                if (done && !seen_done) begin
                    seen_done = 1'b1;
                    check(!busy && rearm && !abort_p, "R7 R9 done idle with rearm",
                          {busy, rearm, abort_p}, 2);
                end
            end
            check(seen_done, "R7 done pulse", seen_done, 1);
            kbd_clk_low = 1'b0; kbd_dat_low = 1'b0;
            repeat (HALF) @(negedge clk);
            check(!busy && !done && !clk_dr && !dat_dr, "R1 idle after transfer",
                  {busy, done, clk_dr, dat_dr}, 0);
        end else begin
            cnt = 0;
            while (!abort_p && cnt < WDOG + 100) begin
                @(negedge clk);
                cnt++;
            end
            total = cnt + HALF;
            check(abort_p && total >= WDOG && total <= WDOG + 8, "R10 abort timing", total, WDOG);
            check(!clk_dr && !dat_dr && !busy && !done && rearm, "R10 R9 abort releases",
                  {clk_dr, dat_dr, busy, done, rearm}, 1);
            repeat (5) @(negedge clk);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!clk_dr && !dat_dr && !busy && !done && !abort_p && !inhibit,
              "R1 reset state", {clk_dr, dat_dr, busy, done, abort_p, inhibit}, 0);
        run_tx(8'hFE, 10, 1'b1, 1'b0);
        run_tx(8'h00, 10, 1'b1, 1'b0);
        run_tx(8'hFF, 10, 1'b1, 1'b1);   // R8: second request during hold
        run_tx(8'h5A, 10, 1'b1, 1'b1);   // R8
        for (int n = 0; n < 10; n++) run_tx(8'($urandom), 10, 1'b1, 1'b0);
        run_tx(8'h3C, 4, 1'b1, 1'b0);    // R10: stall mid frame
        run_tx(8'hC3, 10, 1'b0, 1'b0);   // R10: no acknowledge
        run_tx(8'h81, 10, 1'b1, 1'b0);   // recovery after abort
        check(stab_viol == 0, "R6 data stable while clock high", stab_viol, 0);
        check(inh_viol == 0, "R9 inhibit follows busy", inh_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule